// File: doc/BRIEF.md
# Far Jump Code Segment Checker

This block checks a protected-mode far jump to a new code segment. A request gives a 16-bit selector and a 32-bit target offset. The block picks the global or the local descriptor table from the selector and checks that the 8-byte entry fits inside that table. It then fetches the entry as two 32-bit words through a read port with a valid/ready handshake. Next it applies the type, privilege and presence rules. It unpacks base, limit and default operand size, scaling the limit when the granularity bit is set, and checks the target offset against that limit.

If every check passes, the code-segment cache and the instruction pointer are loaded and a one-cycle done pulse is raised. If a check fails, a one-cycle fault pulse carries a vector and an error code, and no architectural state changes. A system descriptor, which would be a call gate or a task gate, is not handled: it gets its own one-cycle unsupported pulse. The current privilege level (CPL) is the low two bits of the stored code-segment selector. That selector comes out of reset with a parameter value.

Top module: `far_jump_checker`

## Requirements
- R1: A selector whose bits 15:2 are all zero gives a fault with vector 13 and error code 0 one cycle after the request is accepted, and no memory read is made.
- R2: Selector bit 2 set picks the local table (ldt_base/ldt_limit) and clear picks the global table. The first read is at table base plus the selector with bits 2:0 cleared, and the second read is 4 bytes higher.
- R3: When the entry's byte index plus 7 is greater than the table limit, a fault with vector 13 and error code equal to the selector with bits 1:0 cleared is given one cycle after acceptance. An index plus 7 equal to the limit is allowed.
- R4: When the second word's bit 12 (S) is clear, only the unsupported pulse is raised. When S is set but bit 11 (code) is clear, a vector 13 fault is raised.
- R5: For a conforming code segment (second word bit 10 set), a DPL (bits 14:13) greater than CPL gives a vector 13 fault. A requested privilege (selector bits 1:0) above CPL is allowed.
- R6: For a non-conforming code segment, a requested privilege greater than CPL, or a DPL different from CPL, gives a vector 13 fault.
- R7: A clear present bit (second word bit 15) gives a fault with vector 11 and the masked selector as error code. A privilege violation is reported ahead of a missing segment.
- R8: The loaded base is {word1[31:24], word1[7:0], word0[31:16]}. The raw limit is {word1[19:16], word0[15:0]}. When word1 bit 23 is set, the limit is shifted left by 12 with 0xFFF below it. The default size is word1 bit 22.
- R9: A target offset above the effective limit gives a vector 13 fault with the masked selector. An offset equal to the limit is accepted.
- R10: On success, cs_sel becomes the selector with bits 1:0 replaced by CPL, eip becomes the target offset, and done pulses for one cycle.
- R11: Each accepted request produces exactly one pulse on one of done, fault or unsup. On fault or unsup, the code-segment cache and eip keep their values.
- R12: req_ready is high only while idle, and a request offered while busy is ignored. Read wait states (mem_rd_ready low) delay the result by one cycle each. After reset, cs_sel is 0x0008, cs_limit is 0xFFFF, eip is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Jump request |
| req_ready | output | 1 | Idle, request accepted |
| req_sel | input | 16 | Target selector |
| req_off | input | 32 | Target offset |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 32 | Global table limit in bytes |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 32 | Local table limit in bytes |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Read accepted, data valid this cycle |
| mem_rd_addr | output | 32 | Descriptor word byte address |
| mem_rd_data | input | 32 | Descriptor word |
| done | output | 1 | Jump taken (one cycle) |
| fault | output | 1 | Jump refused (one cycle) |
| unsup | output | 1 | System descriptor, not handled (one cycle) |
| fault_vec | output | 8 | Fault vector, 11 or 13 |
| fault_code | output | 16 | Fault error code |
| cs_sel | output | 16 | Code-segment selector |
| cs_base | output | 32 | Code-segment base |
| cs_limit | output | 32 | Code-segment effective limit |
| cs_big | output | 1 | Code-segment 32-bit default size |
| eip | output | 32 | Instruction pointer |

## Verification
A null selector or a table-limit violation is decided at the accepting edge, so it shows up one cycle later. Every other outcome follows the second descriptor read: with no wait states that is three cycles after acceptance, plus one cycle for each cycle mem_rd_ready is held low. The bench counts falling edges from acceptance up to the first result pulse and compares that count with the figure above for every request. It also watches three more cycles to confirm that no second pulse follows. Read addresses are recorded at the falling edge before each handshake edge and compared with the computed entry address.

// File: rtl/far_jump_checker.sv
module far_jump_checker #(
  parameter logic [15:0] RESET_CS_SEL   = 16'h0008,
  parameter logic [31:0] RESET_CS_LIMIT = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_sel,
  input  logic [31:0] req_off,
  input  logic [31:0] gdt_base,
  input  logic [31:0] gdt_limit,
  input  logic [31:0] ldt_base,
  input  logic [31:0] ldt_limit,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic [31:0] mem_rd_data,
  output logic        done,
  output logic        fault,
  output logic        unsup,
  output logic [7:0]  fault_vec,
  output logic [15:0] fault_code,
  output logic [15:0] cs_sel,
  output logic [31:0] cs_base,
  output logic [31:0] cs_limit,
  output logic        cs_big,
  output logic [31:0] eip
);

  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_GP = 8'd13;

  typedef enum logic [1:0] {IDLE, RD_LO, RD_HI} st_t;

  st_t         st;
  logic [15:0] sel_q;
  logic [31:0] off_q;
  logic [31:0] addr_q;
  logic [31:0] lo_q;

  assign req_ready    = (st == IDLE);
  assign mem_rd_valid = (st != IDLE);
  assign mem_rd_addr  = (st == RD_HI) ? addr_q + 32'd4 : addr_q;

  wire        accept   = req_valid && (st == IDLE);
  wire [15:0] idx      = {req_sel[15:3], 3'b000};
  wire [31:0] tbl_base = req_sel[2] ? ldt_base  : gdt_base;
  wire [31:0] tbl_lim  = req_sel[2] ? ldt_limit : gdt_limit;
  wire        sel_null = (req_sel[15:2] == 14'd0);
  wire        tbl_over = ({17'd0, idx} + 33'd7) > {1'b0, tbl_lim};

  wire [31:0] hi       = mem_rd_data;
  wire [19:0] lim_raw  = {hi[19:16], lo_q[15:0]};
  wire [31:0] lim_eff  = hi[23] ? {lim_raw, 12'hFFF} : {12'h000, lim_raw};
  wire [31:0] base_new = {hi[31:24], hi[7:0], lo_q[31:16]};
  wire [1:0]  cpl      = cs_sel[1:0];
  wire [1:0]  rpl      = sel_q[1:0];
  wire [1:0]  dpl      = hi[14:13];
  wire        priv_bad = hi[10] ? (dpl > cpl) : ((rpl > cpl) || (dpl != cpl));
  wire [15:0] sel_m    = {sel_q[15:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      sel_q      <= '0;
      off_q      <= '0;
      addr_q     <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      unsup      <= 1'b0;
      fault_vec  <= '0;
      fault_code <= '0;
      cs_sel     <= RESET_CS_SEL;
      cs_base    <= '0;
      cs_limit   <= RESET_CS_LIMIT;
      cs_big     <= 1'b0;
      eip        <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unsup <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          sel_q <= req_sel;
          off_q <= req_off;
          if (sel_null) begin
            fault      <= 1'b1;
            fault_vec  <= VEC_GP;
            fault_code <= 16'h0000;
          end else if (tbl_over) begin
            fault      <= 1'b1;
            fault_vec  <= VEC_GP;
            fault_code <= {req_sel[15:2], 2'b00};
          end else begin
            addr_q <= tbl_base + {16'd0, idx};
            st     <= RD_LO;
          end
        end
        RD_LO: if (mem_rd_ready) begin
          lo_q <= mem_rd_data;
          st   <= RD_HI;
        end
        RD_HI: if (mem_rd_ready) begin
          st <= IDLE;
          if (!hi[12]) begin
            unsup <= 1'b1;
          end else if (!hi[11] || priv_bad) begin
            fault      <= 1'b1;
            fault_vec  <= VEC_GP;
            fault_code <= sel_m;
          end else if (!hi[15]) begin
            fault      <= 1'b1;
            fault_vec  <= VEC_NP;
            fault_code <= sel_m;
          end else if (off_q > lim_eff) begin
            fault      <= 1'b1;
            fault_vec  <= VEC_GP;
            fault_code <= sel_m;
          end else begin
            done     <= 1'b1;
            cs_sel   <= {sel_q[15:2], cpl};
            cs_base  <= base_new;
            cs_limit <= lim_eff;
            cs_big   <= hi[22];
            eip      <= off_q;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, unsup})); // R11

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || unsup) |-> (cs_sel == $past(cs_sel) && eip == $past(eip) && cs_limit == $past(cs_limit))); // R11

  AST_CPL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_sel[1:0] == $past(cs_sel[1:0])); // R10

  AST_EIP_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> eip <= cs_limit); // R9

  AST_CODE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_code[1:0] == 2'b00); // R7

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_vec == VEC_GP || fault_vec == VEC_NP)); // R7

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R12

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready); // R12

endmodule

// File: tb/test_far_jump_checker.sv
module test_far_jump_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [31:0] gdt_base = 32'h0000_0000;
  logic [31:0] gdt_limit = 32'h0000_007F;
  logic [31:0] ldt_base = 32'h0000_0080;
  logic [31:0] ldt_limit = 32'h0000_003F;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic        done, fault, unsup, cs_big;
  logic [7:0]  fault_vec;
  logic [15:0] fault_code, cs_sel;
  logic [31:0] cs_base, cs_limit, eip;

  logic [31:0] mem [0:63];
  assign mem_rd_data = mem[mem_rd_addr[7:2]];

  int checks = 0;
  int errs = 0;
  int stall_cfg = 0;
  int stall_left = 0;
  int nreads = 0;
  logic [31:0] rd_addr [0:1];

  int          kind, lat, extra;
  logic [7:0]  r_vec;
  logic [15:0] r_code;
  logic [15:0] prev_sel;
  logic [31:0] prev_eip;

  always #4 clk = ~clk;

  far_jump_checker i_far_jump_checker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel), .req_off(req_off),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ldt_base(ldt_base), .ldt_limit(ldt_limit),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .done(done), .fault(fault), .unsup(unsup), .fault_vec(fault_vec), .fault_code(fault_code),
    .cs_sel(cs_sel), .cs_base(cs_base), .cs_limit(cs_limit), .cs_big(cs_big), .eip(eip)
  );

  always @(negedge clk) begin
    if (mem_rd_valid) begin
      if (stall_left == 0) begin
        mem_rd_ready = 1'b1;
        if (nreads < 2) rd_addr[nreads] = mem_rd_addr;
        nreads = nreads + 1;
        stall_left = stall_cfg;
      end else begin
        mem_rd_ready = 1'b0;
        stall_left = stall_left - 1;
      end
    end else begin
      mem_rd_ready = 1'b0;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic put_desc(input int w, input logic [31:0] base, input logic [19:0] lim,
                          input bit g, input bit big, input bit p, input logic [1:0] dpl,
                          input bit s, input logic [3:0] typ);
    mem[w]   = {base[15:0], lim[15:0]};
    mem[w+1] = {base[31:24], g, big, 2'b00, lim[19:16], p, dpl, s, typ, base[23:16]};
  endtask

  task automatic run(input logic [15:0] s, input logic [31:0] o);
    prev_sel = cs_sel;
    prev_eip = eip;
    nreads = 0;
    stall_left = stall_cfg;
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_off = o;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; kind = 0; extra = 0;
    while (kind == 0 && lat < 100) begin
      if (done) kind = 1;
      else if (fault) kind = 2;
      else if (unsup) kind = 3;
      if (kind == 0) begin
        @(negedge clk);
        lat++;
      end
    end
    r_vec = fault_vec;
    r_code = fault_code;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done || fault || unsup) extra++;
    end
    chk("R11 single result pulse", extra, 0);
    if (kind != 1) begin
      chk("R11 selector kept", cs_sel, prev_sel);
      chk("R11 eip kept", eip, prev_eip);
    end
  endtask

  task automatic expect_fault(input string rq, input logic [7:0] v, input logic [15:0] c, input int l);
    chk({rq, " fault kind"}, kind, 2);
    chk({rq, " vector"}, r_vec, v);
    chk({rq, " code"}, r_code, c);
    chk({rq, " latency"}, lat, l);
  endtask

  task automatic t_reset;
    chk("R12 reset cs_sel", cs_sel, 16'h0008);
    chk("R12 reset cs_limit", cs_limit, 32'h0000_FFFF);
    chk("R12 reset eip", eip, 0);
    chk("R12 reset ready", req_ready, 1);
    chk("R12 reset pulses", {done, fault, unsup}, 0);
  endtask

  task automatic t_null;
    run(16'h0003, 32'h10);
    expect_fault("R1 null", 8'd13, 16'h0000, 1);
    chk("R1 no read", nreads, 0);
  endtask

  task automatic t_gdt_ok;
    run(16'h0010, 32'h800);
    chk("R10 done", kind, 1);
    chk("R12 latency", lat, 3);
    chk("R2 first addr", rd_addr[0], 32'h10);
    chk("R2 second addr", rd_addr[1], 32'h14);
    chk("R8 base", cs_base, 32'h1234_5678);
    chk("R8 limit", cs_limit, 32'h0000_0FFF);
    chk("R8 big", cs_big, 1);
    chk("R10 selector", cs_sel, 16'h0010);
    chk("R10 eip", eip, 32'h800);
  endtask

  task automatic t_ldt_conf;
    run(16'h000F, 32'h3FFF);
    chk("R5 conforming rpl3 ok", kind, 1);
    chk("R2 ldt addr", rd_addr[0], 32'h88);
    chk("R2 ldt addr hi", rd_addr[1], 32'h8C);
    chk("R8 granular limit", cs_limit, 32'h0000_3FFF);
    chk("R8 base ldt", cs_base, 32'hAB12_CD34);
    chk("R8 small", cs_big, 0);
    chk("R10 rpl forced", cs_sel, 16'h000C);
    chk("R9 offset at limit", eip, 32'h3FFF);
  endtask

  task automatic t_off_over;
    run(16'h000C, 32'h4000);
    expect_fault("R9 offset over", 8'd13, 16'h000C, 3);
  endtask

  task automatic t_tbl_limit;
    run(16'h003C, 32'h00FF);
    chk("R3 index at limit ok", kind, 1);
    chk("R3 eip", eip, 32'hFF);
    run(16'h0044, 32'h0);
    expect_fault("R3 ldt over", 8'd13, 16'h0044, 1);
    run(16'h0082, 32'h0);
    expect_fault("R3 gdt over", 8'd13, 16'h0080, 1);
  endtask

  task automatic t_types;
    run(16'h0018, 32'h0);
    chk("R4 system unsup", kind, 3);
    chk("R4 latency", lat, 3);
    run(16'h0020, 32'h0);
    expect_fault("R4 data seg", 8'd13, 16'h0020, 3);
  endtask

  task automatic t_priv;
    run(16'h0028, 32'h0);
    expect_fault("R5 conf dpl>cpl", 8'd13, 16'h0028, 3);
    run(16'h0011, 32'h0);
    expect_fault("R6 rpl>cpl", 8'd13, 16'h0010, 3);
    run(16'h0030, 32'h0);
    expect_fault("R6 dpl!=cpl", 8'd13, 16'h0030, 3);
  endtask

  task automatic t_present;
    run(16'h0038, 32'h0);
    expect_fault("R7 not present", 8'd11, 16'h0038, 3);
    run(16'h0040, 32'h0);
    expect_fault("R7 priv before present", 8'd13, 16'h0040, 3);
  endtask

  task automatic t_busy;
    stall_cfg = 2;
    nreads = 0;
    stall_left = stall_cfg;
    prev_eip = eip;
    @(negedge clk);
    req_valid = 1'b1; req_sel = 16'h0010; req_off = 32'h0123;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 busy not ready", req_ready, 0);
    req_valid = 1'b1; req_sel = 16'h0000; req_off = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 3; kind = 0; extra = 0;
    while (kind == 0 && lat < 100) begin
      if (done) kind = 1;
      else if (fault) kind = 2;
      else if (unsup) kind = 3;
      if (kind == 0) begin
        @(negedge clk);
        lat++;
      end
    end
    chk("R12 busy request ignored", kind, 1);
    chk("R12 stall latency", lat, 7);
    chk("R12 stalled eip", eip, 32'h0123);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || fault || unsup) extra++;
    end
    chk("R11 no extra pulse after busy", extra, 0);
    stall_cfg = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    put_desc(4,  32'h1234_5678, 20'h00FFF, 0, 1, 1, 2'd0, 1, 4'hA);
    put_desc(6,  32'h0000_0000, 20'h00FFF, 0, 1, 1, 2'd0, 0, 4'hC);
    put_desc(8,  32'h0000_0000, 20'h00FFF, 0, 1, 1, 2'd0, 1, 4'h2);
    put_desc(10, 32'h0000_0000, 20'h00FFF, 0, 1, 1, 2'd1, 1, 4'hE);
    put_desc(12, 32'h0000_0000, 20'h00FFF, 0, 1, 1, 2'd2, 1, 4'hA);
    put_desc(14, 32'h0000_0000, 20'h00FFF, 0, 1, 0, 2'd0, 1, 4'hA);
    put_desc(16, 32'h0000_0000, 20'h00FFF, 0, 1, 0, 2'd3, 1, 4'hA);
    put_desc(34, 32'hAB12_CD34, 20'h00003, 1, 0, 1, 2'd0, 1, 4'hE);
    put_desc(46, 32'h0040_0000, 20'h000FF, 0, 1, 1, 2'd0, 1, 4'hA);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_null();
    t_gdt_ok();
    t_ldt_conf();
    t_off_over();
    t_tbl_limit();
    t_types();
    t_priv();
    t_present();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule